// File: doc/BRIEF.md
# Scanout Timing Generator with Early-Fetch Interrupt

This block walks a video-mode display interface through its frames. A pixel counter steps across each line, a line counter steps down the frame, and a 32-bit frame counter advances whenever the last line ends. Each frame runs sync pulse, then back porch, then active lines, then front porch. A one-cycle interrupt tells the host when buffered register updates can be committed.

With early fetch turned on, the interrupt moves from the frame end to the first front-porch line. This gives the fetch engine the whole front porch to prefill. The raw frame counter still advances only at the frame end. To hide that gap, the block also provides a corrected frame count that runs one ahead during the early-fetch window. It also provides a signed scanout position measured from the first active line, which goes negative in the blanking that leads into the next frame.

The timing fields are sampled into shadow registers only while the interface is disabled or at the frame boundary. A frame already in progress always completes with the geometry it started with.

Top module: `scan_timing_gen`

## Requirements
- R1: During and right after reset, the line count is 1, the frame count and corrected count are 0, the interrupt is low and both status bits are 0.
- R2: While enabled, the line count advances by one every `h_total_i` clocks. Line 1 is the first sync line. After line vtotal = sync + back + active + front, it returns to 1.
- R3: The raw frame count increases by exactly one, modulo 2^32, in the same clock that the line count returns from vtotal to 1.
- R4: With early fetch enabled, the interrupt is high for exactly the first clock of line sync + back + active + 1, which is the first front-porch line.
- R5: With early fetch disabled, the interrupt is high for exactly the first clock of line 1 after a frame wrap. Enabling the interface on its own does not raise it.
- R6: The corrected count equals raw + 1 when the status enable and status early-fetch bits are both 1 and the line count is greater than sync + back + active and at most vtotal. Otherwise it equals the raw count.
- R7: Let A = sync + back + 1. If the line count is at most A + active, the scanout position is line − A. If it is greater, the position is line − vtotal − A, as a two's-complement value.
- R8: The horizontal total and the four vertical fields are captured while the interface is disabled and in the clock where the frame wraps. Changes at any other time have no effect until that capture.
- R9: While the enable is low, the pixel and line counters sit at line 1, the frame count holds and no interrupt is raised. The two status bits show the enable and early-fetch inputs as sampled on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| pf_en_i | input | 1 | Early-fetch (interrupt in front porch) enable |
| h_total_i | input | HW | Pixel clocks per line |
| v_sync_i | input | LINE_W | Sync pulse length in lines |
| v_back_i | input | LINE_W | Back porch length in lines |
| v_active_i | input | LINE_W | Active line count |
| v_front_i | input | LINE_W | Front porch length in lines |
| line_o | output | LINE_W | Raw line count, 1-based |
| frame_o | output | FW | Raw frame count |
| frame_adj_o | output | FW | Corrected frame count |
| scan_pos_o | output | LINE_W+2 | Signed scanout line relative to first active line |
| stat_en_o | output | 1 | Registered enable status |
| stat_pf_o | output | 1 | Registered early-fetch status |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The embedded properties rely on some assumptions about the programmed geometry. The horizontal total must be at least two, so an interrupt pulse can never run into the next one. Every vertical field must be at least one line, so the fetch line comes strictly before vtotal. The four vertical fields together must fit in the line counter width. The stimulus only programs geometries that meet these limits. It changes them in the middle of a frame and during idle periods, and it switches the early-fetch enable between runs, so the capture rule and both interrupt placements are exercised.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int LINE_W = 12;

  typedef struct packed {
    logic [LINE_W-1:0] sync;
    logic [LINE_W-1:0] back;
    logic [LINE_W-1:0] active;
    logic [LINE_W-1:0] front;
  } vgeom_t;

  function automatic logic [LINE_W-1:0] geom_total(input vgeom_t g);
    return g.sync + g.back + g.active + g.front;
  endfunction

  function automatic logic [LINE_W-1:0] geom_fetch_line(input vgeom_t g);
    return g.sync + g.back + g.active;
  endfunction

  function automatic logic [LINE_W-1:0] geom_first_active(input vgeom_t g);
    return g.sync + g.back + 1'b1;
  endfunction
endpackage

// File: rtl/stg_hcount.sv
module stg_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          reload,
  input  logic [HW-1:0] htot_i,
  output logic          wrap_o
);
  logic [HW-1:0] pix_q;
  logic [HW-1:0] htot_q;

  assign wrap_o = en && (pix_q == htot_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      htot_q <= htot_i;
    end else begin
      if (reload) htot_q <= htot_i;
      if (!en || wrap_o) pix_q <= '0;
      else               pix_q <= pix_q + 1'b1;
    end
  end

  // R2: pixel position stays inside the latched line length
  p_pix_range_r2: assert property (@(posedge clk) disable iff (rst)
    pix_q < htot_q);
endmodule

// File: rtl/stg_vcount.sv
module stg_vcount
  import scan_pkg::*;
#(
  parameter int FW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pf,
  input  logic              wrap_i,
  input  vgeom_t            geom_i,
  output vgeom_t            geom_o,
  output logic              reload_o,
  output logic [LINE_W-1:0] line_o,
  output logic [FW-1:0]     frame_o,
  output logic              irq_o,
  output logic              stat_en_o,
  output logic              stat_pf_o
);
  vgeom_t            geom_q;
  logic [LINE_W-1:0] line_q;
  logic [FW-1:0]     frame_q;
  logic              irq_q, sen_q, spf_q;
  logic [LINE_W-1:0] vtot, fetch_ln;
  logic              frame_end;

  assign vtot      = geom_total(geom_q);
  assign fetch_ln  = geom_fetch_line(geom_q);
  assign frame_end = wrap_i && (line_q == vtot);
  assign reload_o  = !en || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      geom_q  <= geom_i;
      line_q  <= LINE_W'(1);
      frame_q <= '0;
      irq_q   <= 1'b0;
      sen_q   <= 1'b0;
      spf_q   <= 1'b0;
    end else begin
      sen_q <= en;
      spf_q <= pf;
      irq_q <= 1'b0;
      if (reload_o) geom_q <= geom_i;
      if (!en) begin
        line_q <= LINE_W'(1);
      end else if (frame_end) begin
        line_q  <= LINE_W'(1);
        frame_q <= frame_q + 1'b1;
        irq_q   <= !pf;
      end else if (wrap_i) begin
        line_q <= line_q + 1'b1;
        irq_q  <= pf && (line_q == fetch_ln);
      end
    end
  end

  assign geom_o    = geom_q;
  assign line_o    = line_q;
  assign frame_o   = frame_q;
  assign irq_o     = irq_q;
  assign stat_en_o = sen_q;
  assign stat_pf_o = spf_q;

  // R2: line count stays within 1..vtotal
  p_line_range_r2: assert property (@(posedge clk) disable iff (rst)
    (line_q >= LINE_W'(1)) && (line_q <= vtot));
  // R3: frame count only ever steps by one
  p_frame_step_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_q != $past(frame_q)) |-> (frame_q == $past(frame_q) + 1'b1));
  // R5: interrupt lasts a single clock
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R9: no interrupt unless the interface was enabled
  p_irq_en_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sen_q);
endmodule

// File: rtl/stg_report.sv
module stg_report
  import scan_pkg::*;
#(
  parameter int FW = 32,
  localparam int PW = LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  vgeom_t            geom,
  input  logic [LINE_W-1:0] line,
  input  logic [FW-1:0]     frame,
  input  logic              stat_en,
  input  logic              stat_pf,
  output logic [FW-1:0]     frame_adj_o,
  output logic [PW-1:0]     scan_pos_o
);
  logic [LINE_W-1:0] vtot, fetch_ln, first_act, act_end;
  logic              in_window;

  assign vtot      = geom_total(geom);
  assign fetch_ln  = geom_fetch_line(geom);
  assign first_act = geom_first_active(geom);
  assign act_end   = first_act + geom.active;
  assign in_window = stat_en && stat_pf && (line > fetch_ln) && (line <= vtot);

  always_comb begin
    frame_adj_o = in_window ? frame + 1'b1 : frame;
    if (line > act_end)
      scan_pos_o = {2'b00, line} - {2'b00, vtot} - {2'b00, first_act};
    else
      scan_pos_o = {2'b00, line} - {2'b00, first_act};
  end

  // R6: without early fetch the corrected count tracks the raw count
  p_adj_plain_r6: assert property (@(posedge clk) disable iff (rst)
    !(stat_en && stat_pf) |-> (frame_adj_o == frame));
  // R7: inside the active region the position is within 0..active-1
  p_pos_active_r7: assert property (@(posedge clk) disable iff (rst)
    ((line >= first_act) && (line < act_end)) |->
      (!scan_pos_o[PW-1] && (scan_pos_o < {2'b00, geom.active})));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 32,
  localparam int PW = LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              pf_en_i,
  input  logic [HW-1:0]     h_total_i,
  input  logic [LINE_W-1:0] v_sync_i,
  input  logic [LINE_W-1:0] v_back_i,
  input  logic [LINE_W-1:0] v_active_i,
  input  logic [LINE_W-1:0] v_front_i,
  output logic [LINE_W-1:0] line_o,
  output logic [FW-1:0]     frame_o,
  output logic [FW-1:0]     frame_adj_o,
  output logic [PW-1:0]     scan_pos_o,
  output logic              stat_en_o,
  output logic              stat_pf_o,
  output logic              irq_o
);
  vgeom_t geom_in, geom_act;
  logic   wrap, reload;

  assign geom_in = '{sync: v_sync_i, back: v_back_i,
                     active: v_active_i, front: v_front_i};

  stg_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .en(en_i), .reload(reload),
    .htot_i(h_total_i), .wrap_o(wrap)
  );

  stg_vcount #(.FW(FW)) u_v (
    .clk(clk), .rst(rst), .en(en_i), .pf(pf_en_i), .wrap_i(wrap),
    .geom_i(geom_in), .geom_o(geom_act), .reload_o(reload),
    .line_o(line_o), .frame_o(frame_o), .irq_o(irq_o),
    .stat_en_o(stat_en_o), .stat_pf_o(stat_pf_o)
  );

  stg_report #(.FW(FW)) u_r (
    .clk(clk), .rst(rst), .geom(geom_act), .line(line_o), .frame(frame_o),
    .stat_en(stat_en_o), .stat_pf(stat_pf_o),
    .frame_adj_o(frame_adj_o), .scan_pos_o(scan_pos_o)
  );
endmodule

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;
  localparam int HW = 12;
  localparam int FW = 32;
  localparam int LW = scan_pkg::LINE_W;
  localparam int PW = LW + 2;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, pf = 1'b0;
  logic [HW-1:0] htot = 4;
  logic [LW-1:0] vs = 1, vb = 2, va = 3, vf = 2;
  logic [LW-1:0] line_o;
  logic [FW-1:0] frame_o, adj_o;
  logic [PW-1:0] pos_o;
  logic sen_o, spf_o, irq_o;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  scan_timing_gen #(.HW(HW), .FW(FW)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .pf_en_i(pf), .h_total_i(htot),
    .v_sync_i(vs), .v_back_i(vb), .v_active_i(va), .v_front_i(vf),
    .line_o(line_o), .frame_o(frame_o), .frame_adj_o(adj_o),
    .scan_pos_o(pos_o), .stat_en_o(sen_o), .stat_pf_o(spf_o), .irq_o(irq_o)
  );

  typedef struct {
    int line; longint frame; longint adj; int pos;
    bit irq; bit sen; bit spf;
  } exp_t;
  exp_t q[$];

  // reference state built from the requirements
  int mh, ml, mhtot, ms, mb, ma, mf_len;
  longint mfr;
  bit mirq, msen, mspf;

  always @(posedge clk) begin
    exp_t e;
    int vt, fetch, fa, aend;
    bit wrap, reload;
    if (rst) begin
      mh = 0; ml = 1; mfr = 0; mirq = 0; msen = 0; mspf = 0;
      mhtot = htot; ms = vs; mb = vb; ma = va; mf_len = vf;
    end else begin
      vt = ms + mb + ma + mf_len;
      fetch = ms + mb + ma;
      wrap = en && (mh == mhtot - 1);
      reload = !en || (wrap && ml == vt);
      mirq = 0;
      if (!en) begin
        mh = 0; ml = 1;
      end else if (wrap) begin
        mh = 0;
        if (ml == vt) begin ml = 1; mfr = (mfr + 1) % 64'h1_0000_0000; mirq = !pf; end
        else begin mirq = pf && (ml == fetch); ml = ml + 1; end
      end else mh = mh + 1;
      if (reload) begin mhtot = htot; ms = vs; mb = vb; ma = va; mf_len = vf; end
      msen = en; mspf = pf;
    end
    vt = ms + mb + ma + mf_len;
    fetch = ms + mb + ma;
    fa = ms + mb + 1;
    aend = fa + ma;
    e.line = ml; e.frame = mfr; e.irq = mirq; e.sen = msen; e.spf = mspf;
    e.adj = (msen && mspf && ml > fetch && ml <= vt) ? (mfr + 1) % 64'h1_0000_0000 : mfr;
    e.pos = (ml > aend) ? ml - vt - fa : ml - fa;
    q.push_back(e);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R2,R8 line", line_o, e.line);
      chk("R3 frame", frame_o, e.frame);
      chk(e.spf ? "R4 irq" : "R5 irq", irq_o, e.irq);
      chk("R6 corrected", adj_o, e.adj);
      chk("R7 position", $signed(pos_o), e.pos);
      chk("R9 status", {sen_o, spf_o}, {e.sen, e.spf});
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    // R1: reset state before any enable
    chk("R1 line", line_o, 1);
    chk("R1 frame", frame_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 status", {sen_o, spf_o}, 0);
    chk("R1 corrected", adj_o, 0);
    cycles(3);
    en = 1'b1;            // R5: enabling alone raises no pulse
    cycles(100);          // frame end interrupt
    pf = 1'b1;
    cycles(100);          // front porch interrupt (R4)
    htot = 5; vs = 2; vb = 1; va = 4; vf = 3;  // R8: mid-frame change
    cycles(150);
    pf = 1'b0;
    cycles(60);
    en = 1'b0;            // R9: idle holds
    cycles(10);
    htot = 3; vs = 1; vb = 1; va = 2; vf = 1;
    pf = 1'b1;
    cycles(2);
    en = 1'b1;
    cycles(80);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule